// File: doc/BRIEF.md
# 40-bit Multiply-Accumulate Unit

This block is the multiply-accumulate execution slice of a small DSP-style pipeline. It holds a single 40-bit accumulator. An accumulate operation takes the low 16-bit halves of two 32-bit register operands and multiplies them as signed numbers. It adds the product into the accumulator. The 8 bits above the low 32 act as guard bits, so long sums of products do not overflow early.

The accumulator is read back in two slices. One read operation returns the 8 guard bits, zero-extended to 32 bits. The other returns the low 32 bits. Each read produces a register write value and a one-cycle write enable. The pipeline gives the block a valid strobe, the 6-bit function code of the instruction and both operands. The trailing parallel-issue bit of the instruction also arrives, and the block ignores it. Instruction fetch, the register file and opcode decoding sit outside this block.

Internally the multiply and the accumulation sit in separate pipeline stages. A read that directly follows an accumulate sees the updated accumulator because the adder output is forwarded to the read path.

Top module: `mac40_unit`

## Requirements
- R1: With `inValid` high and `inFunc` = 6'b010000, the accumulator increases by signed(`inOpA[15:0]`) × signed(`inOpB[15:0]`). Bits [31:16] of both operands have no effect on it, and `outWrEn` stays low one cycle later.
- R2: The 32-bit product is sign-extended to 40 bits before the addition, and the sum wraps modulo 2^40.
- R3: With `inValid` high and `inFunc` = 6'b010001, `outResult` one cycle later equals {24'b0, acc[39:32]}.
- R4: With `inValid` high and `inFunc` = 6'b010010, `outResult` one cycle later equals acc[31:0].
- R5: A read issued in the cycle directly after one accumulate, or after several back-to-back accumulates, returns the accumulator including every earlier accumulate.
- R6: The accumulator is unchanged when `inValid` is low, or when `inFunc` is any code other than 6'b010000. A code other than the three listed produces no write.
- R7: `inParBit` has no effect on the accumulator, on `outResult` or on `outWrEn`.
- R8: Synchronous reset (`rst` high at a clock edge) clears the accumulator, drops any accumulate still in flight and drives `outWrEn` low.
- R9: `outWrEn` is high in exactly the cycle after a valid read (010001 or 010010) is issued, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation valid strobe |
| inFunc | input | 6 | Function code of the MAC-class instruction |
| inParBit | input | 1 | Parallel-issue bit of the instruction, ignored |
| inOpA | input | 32 | First register operand |
| inOpB | input | 32 | Second register operand |
| outResult | output | 32 | Register write value from an accumulator read |
| outWrEn | output | 1 | Write enable for `outResult` |

## Verification
Two functions can fall in the same cycle. One is the accumulator update of a finishing accumulate. The other is the capture of a read issued right behind it, so in that cycle the read must take the forwarded sum and not the stored accumulator. The bench provokes this with a read issued directly after a single accumulate, and again after a run of back-to-back accumulates. Each returned value is compared with a hand-computed running total. A reset that lands while an accumulate is still in its second stage is also applied, and a following read must return zero.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

  localparam int unsigned OP_W   = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ACC_W  = 40;
  localparam int unsigned FN_W   = 6;

  // Function codes within the MAC-class opcode; the decoder depends on these values.
  localparam logic [FN_W-1:0] FN_ACCUM = 6'b010000;
  localparam logic [FN_W-1:0] FN_RD_HI = 6'b010001;
  localparam logic [FN_W-1:0] FN_RD_LO = 6'b010010;

  // Strobes from control to datapath.
  typedef struct packed {
    logic macEn;
    logic rdHi;
    logic rdLo;
  } mac_strobe_t;

endpackage

// File: rtl/mac40_ctrl.sv
module mac40_ctrl
  import mac40_pkg::*;
#(
  parameter int unsigned FNW = FN_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid,
  input  logic [FNW-1:0] func,
  output mac_strobe_t    strb
);

  always_comb begin
    strb = '0;
    if (valid) begin
      unique case (func)
        FN_ACCUM: strb.macEn = 1'b1;
        FN_RD_HI: strb.rdHi  = 1'b1;
        FN_RD_LO: strb.rdLo  = 1'b1;
        default:  strb       = '0;
      endcase
    end
  end

  // Only one operation may be active per cycle.
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.macEn, strb.rdHi, strb.rdLo}));

endmodule

// File: rtl/mac40_mulstage.sv
module mac40_mulstage #(
  parameter int unsigned OPW   = 32,
  parameter int unsigned HALFW = 16,
  localparam int unsigned PRODW = 2 * HALFW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    macEn,
  input  logic [OPW-1:0]          opA,
  input  logic [OPW-1:0]          opB,
  output logic                    prodValid,
  output logic signed [PRODW-1:0] prodReg
);

  logic signed [HALFW-1:0] aLow;
  logic signed [HALFW-1:0] bLow;
  logic signed [PRODW-1:0] prodComb;

  assign aLow     = opA[HALFW-1:0];
  assign bLow     = opB[HALFW-1:0];
  assign prodComb = PRODW'(aLow) * PRODW'(bLow);

  always_ff @(posedge clk) begin
    if (rst) begin
      prodValid <= 1'b0;
      prodReg   <= '0;
    end else begin
      prodValid <= macEn;
      if (macEn) prodReg <= prodComb;
    end
  end

  // Changing only the upper operand halves between two accumulates leaves the product unchanged.
  p_upper_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(macEn) && macEn && prodValid &&
     opA[HALFW-1:0] == $past(opA[HALFW-1:0]) &&
     opB[HALFW-1:0] == $past(opB[HALFW-1:0]) &&
     (opA[OPW-1:HALFW] != $past(opA[OPW-1:HALFW]) ||
      opB[OPW-1:HALFW] != $past(opB[OPW-1:HALFW])))
    |=> $stable(prodReg));

endmodule

// File: rtl/mac40_accum.sv
module mac40_accum #(
  parameter int unsigned OPW   = 32,
  parameter int unsigned ACCW  = 40,
  parameter int unsigned PRODW = 32,
  localparam int unsigned GUARDW = ACCW - OPW,
  localparam int unsigned EXTW   = ACCW - PRODW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    prodValid,
  input  logic signed [PRODW-1:0] prodReg,
  input  logic                    rdHi,
  input  logic                    rdLo,
  output logic [OPW-1:0]          result,
  output logic                    wrEn
);

  logic [ACCW-1:0] accReg;
  logic [ACCW-1:0] prodExt;
  logic [ACCW-1:0] accNext;
  logic [ACCW-1:0] accView;

  assign prodExt = {{EXTW{prodReg[PRODW-1]}}, prodReg};
  assign accNext = accReg + prodExt;              // wraps modulo 2^ACCW
  assign accView = prodValid ? accNext : accReg;  // forward an in-flight accumulate to reads

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg <= '0;
      result <= '0;
      wrEn   <= 1'b0;
    end else begin
      if (prodValid) accReg <= accNext;
      wrEn <= rdHi | rdLo;
      if (rdHi)
        result <= {{(OPW-GUARDW){1'b0}}, accView[ACCW-1:OPW]};
      else if (rdLo)
        result <= accView[OPW-1:0];
    end
  end

  p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !prodValid |=> $stable(accReg));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (accReg == '0 && !wrEn && !prodValid));

  p_fwd_match_r5: assert property (@(posedge clk) disable iff (rst)
    (prodValid && rdLo) |=> result == accReg[OPW-1:0]);

endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
  import mac40_pkg::*;
#(
  parameter int unsigned OPW   = OP_W,
  parameter int unsigned HALFW = HALF_W,
  parameter int unsigned ACCW  = ACC_W,
  parameter int unsigned FNW   = FN_W,
  localparam int unsigned PRODW  = 2 * HALFW,
  localparam int unsigned GUARDW = ACCW - OPW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [FNW-1:0] inFunc,
  input  logic           inParBit,
  input  logic [OPW-1:0] inOpA,
  input  logic [OPW-1:0] inOpB,
  output logic [OPW-1:0] outResult,
  output logic           outWrEn
);

  mac_strobe_t             strb;
  logic                    prodValid;
  logic signed [PRODW-1:0] prodReg;

  mac40_ctrl #(.FNW(FNW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .valid (inValid),
    .func  (inFunc),
    .strb  (strb)
  );

  mac40_mulstage #(.OPW(OPW), .HALFW(HALFW)) u_mul (
    .clk       (clk),
    .rst       (rst),
    .macEn     (strb.macEn),
    .opA       (inOpA),
    .opB       (inOpB),
    .prodValid (prodValid),
    .prodReg   (prodReg)
  );

  mac40_accum #(.OPW(OPW), .ACCW(ACCW), .PRODW(PRODW)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .prodValid (prodValid),
    .prodReg   (prodReg),
    .rdHi      (strb.rdHi),
    .rdLo      (strb.rdLo),
    .result    (outResult),
    .wrEn      (outWrEn)
  );

  p_wren_source_r9: assert property (@(posedge clk) disable iff (rst)
    outWrEn |-> $past(inValid && (inFunc == FN_RD_HI || inFunc == FN_RD_LO)));

  p_hi_zero_ext_r3: assert property (@(posedge clk) disable iff (rst)
    (outWrEn && $past(inFunc) == FN_RD_HI) |-> outResult[OPW-1:GUARDW] == '0);

  p_par_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (inParBit && !(inValid && (inFunc == FN_RD_HI || inFunc == FN_RD_LO))) |=> !outWrEn);

endmodule

// File: tb/mac40_unit_bench.sv
module mac40_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] F_ACC = 6'b010000;
  localparam logic [5:0] F_HI  = 6'b010001;
  localparam logic [5:0] F_LO  = 6'b010010;

  typedef struct packed {
    logic        v;
    logic [5:0]  f;
    logic        p;
    logic [31:0] a;
    logic [31:0] b;
    logic        expWr;
    logic [31:0] expRes;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, F_ACC, 1'b0, 32'h0000_0003, 32'h0000_0004, 1'b0, 32'h0, 4'd1},        // R1: acc=12
    '{1'b1, F_LO,  1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_000C, 4'd5},                // R5: read right after
    '{1'b1, F_HI,  1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_0000, 4'd3},                // R3
    '{1'b1, F_ACC, 1'b0, 32'hFFFF_FFFF, 32'h1234_0005, 1'b0, 32'h0, 4'd1},        // R1: -5, acc=7
    '{1'b1, F_ACC, 1'b1, 32'h0000_7FFF, 32'h0000_7FFF, 1'b0, 32'h0, 4'd7},        // R7: acc=3FFF0008
    '{1'b1, F_LO,  1'b0, 32'h0, 32'h0, 1'b1, 32'h3FFF_0008, 4'd5},                // R5: back-to-back
    '{1'b0, F_ACC, 1'b0, 32'h0000_1234, 32'h0000_5678, 1'b0, 32'h0, 4'd6},        // R6: valid low
    '{1'b1, 6'h3F, 1'b0, 32'h0000_1234, 32'h0000_5678, 1'b0, 32'h0, 4'd6},        // R6: unknown code
    '{1'b1, F_LO,  1'b0, 32'h0, 32'h0, 1'b1, 32'h3FFF_0008, 4'd6},                // R6: unchanged
    '{1'b1, F_ACC, 1'b0, 32'h0000_8000, 32'h0000_8000, 1'b0, 32'h0, 4'd2},        // R2: acc=7FFF0008
    '{1'b1, F_ACC, 1'b0, 32'h0000_8000, 32'h0000_8000, 1'b0, 32'h0, 4'd2},        // acc=BFFF0008
    '{1'b1, F_ACC, 1'b0, 32'h0000_8000, 32'h0000_8000, 1'b0, 32'h0, 4'd2},        // acc=FFFF0008
    '{1'b1, F_ACC, 1'b0, 32'h0000_8000, 32'h0000_8000, 1'b0, 32'h0, 4'd2},        // acc=1_3FFF0008
    '{1'b1, F_HI,  1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_0001, 4'd3},                // R3: guard bits
    '{1'b1, F_LO,  1'b0, 32'h0, 32'h0, 1'b1, 32'h3FFF_0008, 4'd4},                // R4
    '{1'b1, F_LO,  1'b1, 32'h0, 32'h0, 1'b1, 32'h3FFF_0008, 4'd7}                 // R7: par on read
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [5:0]  inFunc;
  logic        inParBit;
  logic [31:0] inOpA;
  logic [31:0] inOpB;
  logic [31:0] outResult;
  logic        outWrEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac40_unit u_mac40_unit (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inFunc    (inFunc),
    .inParBit  (inParBit),
    .inOpA     (inOpA),
    .inOpB     (inOpB),
    .outResult (outResult),
    .outWrEn   (outWrEn)
  );

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, check the registered outputs one edge later.
  task automatic issue(input logic v, input logic [5:0] f, input logic p,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic expWr, input logic [31:0] expRes, input string req);
    inValid = v; inFunc = f; inParBit = p; inOpA = a; inOpB = b;
    @(negedge clk);
    inValid = 1'b0; inFunc = '0; inParBit = 1'b0; inOpA = '0; inOpB = '0;
    checkVal({req, " wrEn (R9)"}, {31'b0, outWrEn}, {31'b0, expWr});
    if (expWr) checkVal({req, " result"}, outResult, expRes);
  endtask

  initial begin
    rst = 1'b1; inValid = 1'b0; inFunc = '0; inParBit = 1'b0; inOpA = '0; inOpB = '0;
    repeat (2) @(negedge clk);
    checkVal("R8 reset wrEn", {31'b0, outWrEn}, 32'h0);
    rst = 1'b0;
    issue(1'b1, F_LO, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0, "R8 reset acc");

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].v, VECS[i].f, VECS[i].p, VECS[i].a, VECS[i].b,
            VECS[i].expWr, VECS[i].expRes, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // Reset landing while an accumulate is in its second stage (R8).
    issue(1'b1, F_ACC, 1'b0, 32'h0000_0100, 32'h0000_0100, 1'b0, 32'h0, "R8 pre");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    issue(1'b1, F_LO, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0, "R8 inflight dropped");
    issue(1'b1, F_HI, 1'b0, 32'h0, 32'h0, 1'b1, 32'h0, "R8 guard cleared");

    // Negative product sign extension and modulo-2^40 wrap (R2).
    issue(1'b1, F_ACC, 1'b0, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 32'h0, "R2 minus one");
    issue(1'b1, F_HI,  1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_00FF, "R2 sign ext hi");
    issue(1'b1, F_LO,  1'b0, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, "R2 sign ext lo");
    issue(1'b1, F_ACC, 1'b0, 32'hABCD_0001, 32'h0000_0001, 1'b0, 32'h0, "R1 upper ignored");
    issue(1'b1, F_LO,  1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_0000, "R2 wrap lo");
    issue(1'b1, F_HI,  1'b0, 32'h0, 32'h0, 1'b1, 32'h0000_0000, "R2 wrap hi");
    @(negedge clk);
    checkVal("R9 idle wrEn", {31'b0, outWrEn}, 32'h0);

    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule